// File: doc/BRIEF.md
# Filtered Two-Phase Hash Join Unit

This unit accelerates an equality join between two tables. During the build phase the smaller table arrives as a stream of records, each made of a join key and the external address of its row. The key is hashed to a bucket index. The unit marks that bucket in an on-chip filter bit vector and stores the key and address in an on-chip entry table. Records that land in the same bucket are linked into a chain, with the newest record at the head.

During the probe phase the second table is streamed through the same hash. If the bucket's filter bit is clear, the probe record is discarded in the cycle it is accepted. Otherwise the probe input is stalled while the chain is walked one entry per cycle. Every stored entry whose key equals the probe key produces a fetch request that carries both row addresses. A start command empties the filter and the chains before a new build. Once the entry table is full, further build records are dropped and a sticky error flag is raised.

Top module: `hash_join_engine`

## Requirements
- R1: The bucket index of a key is the XOR of its consecutive IDX_W-bit slices, taken from bit 0 upward, with the top slice zero-padded.
- R2: A cycle with start_build high clears the filter, all chains, the entry count and overflow_err. In that cycle build_ready and probe_ready are low.
- R3: An accepted build record, while the table has room, sets its bucket's filter bit and becomes the new head of that bucket's chain.
- R4: When DEPTH entries are held, an accepted build record is dropped and overflow_err goes high. overflow_err stays high until the next start_build, and the dropped record never produces a match.
- R5: An accepted probe record whose bucket filter bit is clear produces no match and no stall: probe_ready is high again at the next cycle.
- R6: An accepted probe record whose bucket bit is set holds probe_ready (and build_ready) low for exactly as many cycles as the chain holds entries.
- R7: Each chain entry whose key equals the probe key yields exactly one match_valid pulse, carrying that entry's build address and the probe address. Pulses come newest entry first. Entries with other keys in the same bucket yield nothing.
- R8: While build_valid is high, probe_ready is low (build records take priority).
- R9: After reset the table is empty, both ready outputs are high, and match_valid and overflow_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_build | input | 1 | Empty filter and chains for a new build |
| build_valid | input | 1 | Build record present |
| build_key | input | KEY_W | Build join key |
| build_raddr | input | RADDR_W | Build row external address |
| build_ready | output | 1 | Build record accepted this cycle if valid |
| probe_valid | input | 1 | Probe record present |
| probe_key | input | KEY_W | Probe join key |
| probe_raddr | input | RADDR_W | Probe row external address |
| probe_ready | output | 1 | Probe record accepted this cycle if valid |
| match_valid | output | 1 | Fetch request for one matching build row |
| match_build_raddr | output | RADDR_W | Address of the matching build row |
| match_probe_raddr | output | RADDR_W | Address of the probe row that matched |
| overflow_err | output | 1 | Sticky: a build record was dropped because the table was full |

## Verification
The bench builds the unit with 8-bit keys and addresses, 3-bit bucket indices (8 buckets) and a 6-entry table. This size lets seven build records fill the table and then overflow it, with duplicate keys and bucket collisions among them. It also makes it practical to probe every one of the 256 key values. For each probe the bench computes the bucket arithmetically, predicts the stall length and the exact ordered list of fetch requests, and compares them. This covers empty buckets, buckets holding only other keys, duplicate keys, and the dropped record. A second build after a restart checks the clearing.

// File: rtl/hj_pkg.sv
package hj_pkg;
   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_BUSY = 1'b1
   } walk_e;
endpackage

// File: rtl/hj_hash.sv
module hj_hash #(
   parameter int KEY_W = 8,
   parameter int IDX_W = 3
) (
   input  logic [KEY_W-1:0] key,
   output logic [IDX_W-1:0] idx
);
   localparam int NSLICE = (KEY_W + IDX_W - 1) / IDX_W;
   localparam int PAD_W  = NSLICE * IDX_W;

   if (IDX_W < 1 || IDX_W > KEY_W) begin : g_bad_width
      $error("hj_hash: IDX_W must lie in 1..KEY_W");
   end

   logic [PAD_W-1:0] padded;
   logic [IDX_W-1:0] slice [NSLICE];

   if (PAD_W > KEY_W) begin : g_pad
      assign padded = {{(PAD_W - KEY_W){1'b0}}, key};
   end else begin : g_nopad
      assign padded = key;
   end

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      assign slice[s] = padded[s*IDX_W +: IDX_W];
   end

   always_comb begin
      idx = '0;
      for (int s = 0; s < NSLICE; s++) begin
         idx = idx ^ slice[s];
      end
   end
endmodule

// File: rtl/hj_filter.sv
module hj_filter #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [IDX_W-1:0] test_idx,
   output logic             hit
);
   localparam int NBUCKET = 1 << IDX_W;

   if (NBUCKET > 4096) begin : g_too_big
      $error("hj_filter: IDX_W too large");
   end

   logic [NBUCKET-1:0] bits_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         bits_q <= '0;
      end else if (set_en) begin
         bits_q[set_idx] <= 1'b1;
      end
   end

   assign hit = bits_q[test_idx];

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (bits_q == '0));
endmodule

// File: rtl/hj_table.sv
module hj_table #(
   parameter int KEY_W   = 8,
   parameter int RADDR_W = 8,
   parameter int IDX_W   = 3,
   parameter int DEPTH   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               ins_en,
   input  logic [IDX_W-1:0]   ins_idx,
   input  logic [KEY_W-1:0]   ins_key,
   input  logic [RADDR_W-1:0] ins_raddr,
   input  logic [IDX_W-1:0]   look_idx,
   output logic [$clog2(DEPTH)-1:0] look_head,
   input  logic [$clog2(DEPTH)-1:0] rd_ptr,
   output logic [KEY_W-1:0]   rd_key,
   output logic [RADDR_W-1:0] rd_raddr,
   output logic [$clog2(DEPTH)-1:0] rd_next,
   output logic               rd_last,
   output logic               full,
   output logic               err
);
   localparam int PTR_W   = $clog2(DEPTH);
   localparam int NBUCKET = 1 << IDX_W;
   localparam logic [PTR_W:0] DEPTH_C = (PTR_W+1)'(DEPTH);

   if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
      $error("hj_table: DEPTH must lie in 2..1024");
   end

   logic [KEY_W-1:0]   key_q   [DEPTH];
   logic [RADDR_W-1:0] raddr_q [DEPTH];
   logic [PTR_W-1:0]   next_q  [DEPTH];
   logic               last_q  [DEPTH];
   logic [PTR_W-1:0]   head_q  [NBUCKET];
   logic [NBUCKET-1:0] headv_q;
   logic [PTR_W:0]     fill_q;
   logic               err_q;
   logic [PTR_W-1:0]   wr_ptr;

   assign full   = (fill_q == DEPTH_C);
   assign wr_ptr = fill_q[PTR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         fill_q  <= '0;
         err_q   <= 1'b0;
         headv_q <= '0;
      end else if (ins_en) begin
         if (full) begin
            err_q <= 1'b1;
         end else begin
            fill_q           <= fill_q + 1'b1;
            headv_q[ins_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (ins_en && !full && !clr && rst_n) begin
         key_q[wr_ptr]   <= ins_key;
         raddr_q[wr_ptr] <= ins_raddr;
         next_q[wr_ptr]  <= head_q[ins_idx];
         last_q[wr_ptr]  <= !headv_q[ins_idx];
         head_q[ins_idx] <= wr_ptr;
      end
   end

   assign look_head = head_q[look_idx];
   assign rd_key    = key_q[rd_ptr];
   assign rd_raddr  = raddr_q[rd_ptr];
   assign rd_next   = next_q[rd_ptr];
   assign rd_last   = last_q[rd_ptr];
   assign err       = err_q;

   assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= DEPTH_C);
   assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr) |=> err_q);
   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (fill_q == '0 && !err_q));
endmodule

// File: rtl/hash_join_engine.sv
module hash_join_engine #(
   parameter int KEY_W   = 8,
   parameter int RADDR_W = 8,
   parameter int IDX_W   = 3,
   parameter int DEPTH   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_build,
   input  logic               build_valid,
   input  logic [KEY_W-1:0]   build_key,
   input  logic [RADDR_W-1:0] build_raddr,
   output logic               build_ready,
   input  logic               probe_valid,
   input  logic [KEY_W-1:0]   probe_key,
   input  logic [RADDR_W-1:0] probe_raddr,
   output logic               probe_ready,
   output logic               match_valid,
   output logic [RADDR_W-1:0] match_build_raddr,
   output logic [RADDR_W-1:0] match_probe_raddr,
   output logic               overflow_err
);
   import hj_pkg::*;
   localparam int PTR_W = $clog2(DEPTH);

   if (KEY_W < 1 || RADDR_W < 1) begin : g_bad_cfg
      $error("hash_join_engine: widths must be positive");
   end

   walk_e              st_q;
   logic [PTR_W-1:0]   ptr_q;
   logic [KEY_W-1:0]   pkey_q;
   logic [RADDR_W-1:0] praddr_q;
   logic [IDX_W-1:0]   b_idx, p_idx;
   logic [PTR_W-1:0]   head_ptr, rd_next;
   logic [KEY_W-1:0]   rd_key;
   logic [RADDR_W-1:0] rd_raddr;
   logic               rd_last, tbl_full, p_hit;
   logic               build_fire, probe_fire;

   assign build_ready = !start_build && (st_q == WALK_IDLE);
   assign probe_ready = build_ready && !build_valid;
   assign build_fire  = build_valid && build_ready;
   assign probe_fire  = probe_valid && probe_ready;

   hj_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash_b (.key(build_key), .idx(b_idx));
   hj_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash_p (.key(probe_key), .idx(p_idx));

   hj_filter #(.IDX_W(IDX_W)) u_filter (
      .clk(clk), .rst_n(rst_n), .clr(start_build),
      .set_en(build_fire && !tbl_full), .set_idx(b_idx),
      .test_idx(p_idx), .hit(p_hit));

   hj_table #(.KEY_W(KEY_W), .RADDR_W(RADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_table (
      .clk(clk), .rst_n(rst_n), .clr(start_build),
      .ins_en(build_fire), .ins_idx(b_idx), .ins_key(build_key), .ins_raddr(build_raddr),
      .look_idx(p_idx), .look_head(head_ptr),
      .rd_ptr(ptr_q), .rd_key(rd_key), .rd_raddr(rd_raddr),
      .rd_next(rd_next), .rd_last(rd_last),
      .full(tbl_full), .err(overflow_err));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q              <= WALK_IDLE;
         ptr_q             <= '0;
         pkey_q            <= '0;
         praddr_q          <= '0;
         match_valid       <= 1'b0;
         match_build_raddr <= '0;
         match_probe_raddr <= '0;
      end else begin
         match_valid <= 1'b0;
         case (st_q)
            WALK_IDLE: begin
               if (probe_fire && p_hit) begin
                  st_q     <= WALK_BUSY;
                  ptr_q    <= head_ptr;
                  pkey_q   <= probe_key;
                  praddr_q <= probe_raddr;
               end
            end
            default: begin
               match_valid       <= (rd_key == pkey_q);
               match_build_raddr <= rd_raddr;
               match_probe_raddr <= praddr_q;
               if (rd_last) st_q <= WALK_IDLE;
               else         ptr_q <= rd_next;
            end
         endcase
      end
   end

   assert_filter_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_fire && !p_hit) |=> (st_q == WALK_IDLE && !match_valid));
   assert_match_from_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == WALK_IDLE) |=> !match_valid);
   assert_walk_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_fire && p_hit) |=> (st_q == WALK_BUSY && !probe_ready));
   assert_build_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (build_valid && build_ready) |-> !probe_fire);
endmodule

// File: tb/tb_hash_join_engine.sv
`timescale 1ns/1ps
module tb_hash_join_engine;
   localparam int KW = 8, AW = 8, IW = 3, DP = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_build = 0, build_valid = 0, probe_valid = 0;
   logic [KW-1:0] build_key = 0, probe_key = 0;
   logic [AW-1:0] build_raddr = 0, probe_raddr = 0;
   logic build_ready, probe_ready, match_valid, overflow_err;
   logic [AW-1:0] match_build_raddr, match_probe_raddr;

   int n_chk = 0, n_bad = 0;
   int m_key [DP];
   int m_adr [DP];
   int m_cnt = 0;

   always #2 clk = ~clk;

   hash_join_engine #(.KEY_W(KW), .RADDR_W(AW), .IDX_W(IW), .DEPTH(DP)) dut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int bucket(input int k);
      int h = 0;
      for (int i = 0; i < 3; i++) h = h ^ ((k >> (IW*i)) & 7);
      return h;
   endfunction

   task automatic do_build(input int k, input int a);
      @(negedge clk);
      chk(build_ready, "R3 build_ready", build_ready, 1);
      build_valid = 1; build_key = k[KW-1:0]; build_raddr = a[AW-1:0];
      @(posedge clk);
      @(negedge clk);
      build_valid = 0;
      if (m_cnt < DP) begin m_key[m_cnt] = k; m_adr[m_cnt] = a; m_cnt++; end
   endtask

   task automatic do_probe(input int k, input int a);
      int exp_len, len, got, expn;
      int exp_adr [DP];
      exp_len = 0; expn = 0;
      for (int i = m_cnt - 1; i >= 0; i--) begin
         if (bucket(m_key[i]) == bucket(k)) exp_len++;
         if (m_key[i] == k) begin exp_adr[expn] = m_adr[i]; expn++; end
      end
      @(negedge clk);
      probe_valid = 1; probe_key = k[KW-1:0]; probe_raddr = a[AW-1:0];
      @(posedge clk);
      len = 0; got = 0;
      for (int c = 0; c < DP + 3; c++) begin
         @(negedge clk);
         probe_valid = 0;
         if (match_valid) begin
            if (got < expn) begin
               chk(match_build_raddr == exp_adr[got][AW-1:0], "R7 build addr order",
                   match_build_raddr, exp_adr[got]);
               chk(match_probe_raddr == a[AW-1:0], "R7 probe addr", match_probe_raddr, a);
            end
            got++;
         end
         if (probe_ready) break;
         len++;
      end
      if (exp_len == 0) chk(len == 0, "R5 R1 no stall on clear bit", len, 0);
      else              chk(len == exp_len, "R6 R1 stall equals chain length", len, exp_len);
      if (k == 8'h77) chk(got == 0, "R4 dropped record never matches", got, 0);
      else            chk(got == expn, "R7 match count", got, expn);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      chk(build_ready && probe_ready, "R9 readys after reset", {build_ready, probe_ready}, 3);
      chk(!match_valid && !overflow_err, "R9 outputs low", {match_valid, overflow_err}, 0);
      do_probe(8'h11, 8'h01);

      start_build = 1;
      @(negedge clk);
      chk(!build_ready && !probe_ready, "R2 readys low in start", {build_ready, probe_ready}, 0);
      @(posedge clk);
      @(negedge clk); start_build = 0;

      do_build(8'h11, 8'hA0);
      do_build(8'h11, 8'hA1);
      do_build(8'h0A, 8'hA2);
      do_build(8'h40, 8'hA3);
      do_build(8'hC5, 8'hA4);
      do_build(8'h33, 8'hA5);
      chk(!overflow_err, "R4 no error at exactly full", overflow_err, 0);
      do_build(8'h77, 8'hA6);
      chk(overflow_err, "R4 error on overflow", overflow_err, 1);

      for (int k = 0; k < 256; k++) do_probe(k, (k * 3 + 5) & 8'hFF);
      chk(overflow_err, "R4 error sticky", overflow_err, 1);

      @(negedge clk);
      build_valid = 1; build_key = 8'h77; probe_valid = 1; probe_key = 8'h11;
      #0.5;
      chk(!probe_ready && build_ready, "R8 build priority", {build_ready, probe_ready}, 2);
      @(posedge clk);
      @(negedge clk); build_valid = 0; probe_valid = 0;

      start_build = 1;
      @(posedge clk);
      @(negedge clk); start_build = 0;
      chk(!overflow_err, "R2 error cleared", overflow_err, 1'b0);
      m_cnt = 0;
      do_probe(8'h11, 8'h22);
      do_build(8'h5C, 8'hB0);
      do_probe(8'h5C, 8'h33);
      do_probe(8'h5D, 8'h34);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule